// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Builder

This block assembles the 256-byte presence-detect image that describes an SDRAM module. The caller supplies a memory type code and a module capacity, given as the base-two logarithm of the size in megabytes. After a one-cycle start pulse the engine validates the request. It then picks how many banks the capacity is spread over and derives the per-bank density, encoded in the way the chosen memory type expects. It writes every byte of the image into an internal byte RAM and finally stores an 8-bit checksum.

The engine runs in fixed phases. First comes a decode cycle. Next is a fill pass that writes the final value of each of the 256 addresses. A summing pass follows that reads back the checksum range one byte per cycle. The last phase is a single checksum write. Completion is signalled by a one-cycle done pulse. Requests that cannot be encoded end at the decode cycle, with done and a sticky error flag. A plain asynchronous read port lets the surrounding logic fetch the finished image.

Top module: `spd_image_gen`

## Requirements
- R1: After reset, busy, done and error are all low.
- R2: Accepted type codes are 0x04 (SDR), 0x07 (DDR) and 0x08 (DDR2). Each type has a minimum size exponent: 2 for SDR, 5 for DDR and 7 for DDR2. An unknown code, or an exponent below the type's minimum, raises error together with the done pulse. error stays high until the next accepted start, and a good run ends with error low.
- R3: The bank count starts at one. While the exponent exceeds the type's maximum (9 for SDR, 12 for DDR, 14 for DDR2) and fewer than 8 banks are in use, the exponent drops by one and the bank count doubles.
- R4: If that loop ends with a single bank and the exponent is still above the type minimum, the module is split into two banks and the exponent drops by one more.
- R5: Byte 31 holds the packed density. The raw value is d = 2^(exponent-2). For SDR the byte is the low 8 bits of d. For DDR it is (d & 0xF8) | ((d >> 8) & 0x07). For DDR2 it is (d & 0xE0) | ((d >> 8) & 0x1F).
- R6: Byte 5 holds the bank count minus one for DDR2, and the bank count itself for SDR and DDR.
- R7: Byte 2 holds the type code. Bytes 15 and 19 are 0 for DDR2 and 1 otherwise. Byte 21 is 0x00 for DDR2 and 0x20 otherwise.
- R8: The remaining defined bytes are fixed: 0=128, 1=8, 3=13, 4=10, 6=64, 8=4, 9=0x25, 10=1, 12=0x82, 13=8, 16=12, 17=4, 18=12, 20=2, 23=0x12, 27=20, 28=15, 29=20, 30=45, 32=20, 33=8, 34=20, 35=8. Every other byte from 0 to 255, except 63, is zero, even after an earlier run left other contents.
- R9: Byte 63 equals the sum of bytes 0 through 62, modulo 256.
- R10: busy is high from the cycle after an accepted start until done. done lasts exactly one cycle and is never high together with busy. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a build when idle |
| mem_type | input | 8 | Memory type code |
| size_log2 | input | 5 | log2 of module size in MB |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request was rejected |
| rd_addr | input | 8 | Image read address |
| rd_data | output | 8 | Image byte at rd_addr |

## Verification
The bench goes after the exponents at each type's minimum and maximum, and after sizes large enough to hit the eight-bank cap. A wrong loop bound or cap changes byte 5 and shifts the density byte. It also covers sizes where the raw density needs more than eight bits. A packing mask taken from the wrong type shows up there as a wrong byte 31 only for DDR and DDR2. Back-to-back runs of different types check that nothing stale survives the fill pass and that a rejected request is followed by a clean result. A start pulse in the middle of a run must leave the image describing the first request.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam logic [7:0] TYPE_SDR  = 8'h04;
    localparam logic [7:0] TYPE_DDR  = 8'h07;
    localparam logic [7:0] TYPE_DDR2 = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_FILL,
        ST_SUM,
        ST_CSUM
    } phase_e;

    typedef struct packed {
        logic [3:0] banks;
        logic [7:0] bank_byte;
        logic [7:0] dens_byte;
        logic       reject;
    } geom_t;

endpackage

// File: rtl/spd_geometry.sv
module spd_geometry
    import spd_pkg::*;
#(
    parameter int LOG_W     = 5,
    parameter int MAX_BANKS = 8
) (
    input  logic [7:0]       type_code,
    input  logic [LOG_W-1:0] exp_in,
    output geom_t            geom
);
    localparam int HALVINGS = $clog2(MAX_BANKS);

    logic [LOG_W-1:0] lo_lim;
    logic [LOG_W-1:0] hi_lim;
    logic             known;
    logic [LOG_W-1:0] exp_w;
    logic [3:0]       nb;
    logic [31:0]      raw;

    always_comb begin
        known  = 1'b1;
        lo_lim = LOG_W'(2);
        hi_lim = LOG_W'(9);
        case (type_code)
            TYPE_SDR:  begin lo_lim = LOG_W'(2); hi_lim = LOG_W'(9);  end
            TYPE_DDR:  begin lo_lim = LOG_W'(5); hi_lim = LOG_W'(12); end
            TYPE_DDR2: begin lo_lim = LOG_W'(7); hi_lim = LOG_W'(14); end
            default:   known = 1'b0;
        endcase

        exp_w = exp_in;
        nb    = 4'd1;
        for (int i = 0; i < HALVINGS; i++) begin
            if (exp_w > hi_lim && nb < 4'(MAX_BANKS)) begin
                exp_w = exp_w - 1'b1;
                nb    = nb << 1;
            end
        end
        if (nb == 4'd1 && exp_w > lo_lim) begin
            exp_w = exp_w - 1'b1;
            nb    = 4'd2;
        end

        raw = (exp_w >= LOG_W'(2)) ? (32'd1 << (exp_w - LOG_W'(2))) : 32'd0;

        geom.banks  = nb;
        geom.reject = !known || (exp_in < lo_lim);
        case (type_code)
            TYPE_DDR2: begin
                geom.dens_byte = (raw[7:0] & 8'hE0) | ({3'b000, raw[12:8]});
                geom.bank_byte = {4'd0, nb} - 8'd1;
            end
            TYPE_DDR: begin
                geom.dens_byte = (raw[7:0] & 8'hF8) | ({5'b00000, raw[10:8]});
                geom.bank_byte = {4'd0, nb};
            end
            default: begin
                geom.dens_byte = raw[7:0];
                geom.bank_byte = {4'd0, nb};
            end
        endcase
    end

endmodule

// File: rtl/spd_field_rom.sv
module spd_field_rom
    import spd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [7:0]        type_code,
    input  logic [7:0]        bank_byte,
    input  logic [7:0]        dens_byte,
    output logic [7:0]        value
);
    logic is_ddr2;
    assign is_ddr2 = (type_code == TYPE_DDR2);

    always_comb begin
        value = 8'h00;
        case (32'(idx))
            0:  value = 8'd128;
            1:  value = 8'd8;
            2:  value = type_code;
            3:  value = 8'd13;
            4:  value = 8'd10;
            5:  value = bank_byte;
            6:  value = 8'd64;
            8:  value = 8'd4;
            9:  value = 8'h25;
            10: value = 8'd1;
            12: value = 8'h82;
            13: value = 8'd8;
            15: value = is_ddr2 ? 8'd0 : 8'd1;
            16: value = 8'd12;
            17: value = 8'd4;
            18: value = 8'd12;
            19: value = is_ddr2 ? 8'd0 : 8'd1;
            20: value = 8'd2;
            21: value = is_ddr2 ? 8'h00 : 8'h20;
            23: value = 8'h12;
            27: value = 8'd20;
            28: value = 8'd15;
            29: value = 8'd20;
            30: value = 8'd45;
            31: value = dens_byte;
            32: value = 8'd20;
            33: value = 8'd8;
            34: value = 8'd20;
            35: value = 8'd8;
            default: value = 8'h00;
        endcase
    end

endmodule

// File: rtl/spd_byte_ram.sv
module spd_byte_ram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [7:0]        ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [7:0]        rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
    import spd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LOG_W     = 5,
    parameter int MAX_BANKS = 8,
    parameter int CSUM_POS  = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        mem_type,
    input  logic [LOG_W-1:0]  size_log2,
    output logic              busy,
    output logic              done,
    output logic              error,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'((1 << ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] SUM_LAST = ADDR_W'(CSUM_POS - 1);
    localparam logic [ADDR_W-1:0] CSUM_IDX = ADDR_W'(CSUM_POS);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] idx;
        logic [7:0]        acc;
        logic [7:0]        tcode;
        logic [LOG_W-1:0]  exp_l;
        logic [3:0]        banks;
        logic [7:0]        bank_byte;
        logic [7:0]        dens_byte;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;
    geom_t geom;
    logic [7:0]        field_val;
    logic [7:0]        sum_rd;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    spd_geometry #(.LOG_W(LOG_W), .MAX_BANKS(MAX_BANKS)) u_geom (
        .type_code (r_q.tcode),
        .exp_in    (r_q.exp_l),
        .geom      (geom)
    );

    spd_field_rom #(.ADDR_W(ADDR_W)) u_rom (
        .idx       (r_q.idx),
        .type_code (r_q.tcode),
        .bank_byte (r_q.bank_byte),
        .dens_byte (r_q.dens_byte),
        .value     (field_val)
    );

    spd_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (r_q.idx),
        .ra_data (sum_rd),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = r_q.idx;
        wr_data  = field_val;
        case (r_q.phase)
            ST_IDLE: begin
                if (start) begin
                    r_d.tcode = mem_type;
                    r_d.exp_l = size_log2;
                    r_d.err   = 1'b0;
                    r_d.phase = ST_CALC;
                end
            end
            ST_CALC: begin
                if (geom.reject) begin
                    r_d.err   = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.phase = ST_IDLE;
                end else begin
                    r_d.banks     = geom.banks;
                    r_d.bank_byte = geom.bank_byte;
                    r_d.dens_byte = geom.dens_byte;
                    r_d.idx       = '0;
                    r_d.phase     = ST_FILL;
                end
            end
            ST_FILL: begin
                wr_en = 1'b1;
                if (r_q.idx == LAST_IDX) begin
                    r_d.idx   = '0;
                    r_d.acc   = 8'h00;
                    r_d.phase = ST_SUM;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_SUM: begin
                r_d.acc = r_q.acc + sum_rd;
                if (r_q.idx == SUM_LAST) begin
                    r_d.phase = ST_CSUM;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_CSUM: begin
                wr_en     = 1'b1;
                wr_addr   = CSUM_IDX;
                wr_data   = r_q.acc;
                r_d.done  = 1'b1;
                r_d.phase = ST_IDLE;
            end
            default: r_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: ST_IDLE, idx: '0, acc: '0, tcode: '0, exp_l: '0,
                     banks: 4'd1, bank_byte: '0, dens_byte: '0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.phase != ST_IDLE);
    assign done  = r_q.done;
    assign error = r_q.err;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.tcode) && $stable(r_q.exp_l)));
    p_error_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
    p_banks_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == ST_FILL) |-> ($countones(r_q.banks) == 1));
    p_no_write_in_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == ST_SUM) |-> !wr_en);

endmodule

// File: tb/spd_image_gen_bench.sv
module spd_image_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] mem_type = 8'h00;
    logic [4:0] size_log2 = 5'd0;
    logic       busy, done, error;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    spd_image_gen u_spd_image_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
        .size_log2(size_log2), .busy(busy), .done(done), .error(error),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {type, exponent, expect_error, byte5, byte31}
    localparam int NV = 17;
    localparam logic [39:0] VEC [NV] = '{
        {8'h04, 8'd2,  8'd0, 8'd1, 8'h01},
        {8'h04, 8'd9,  8'd0, 8'd2, 8'h40},
        {8'h04, 8'd10, 8'd0, 8'd2, 8'h80},
        {8'h04, 8'd12, 8'd0, 8'd8, 8'h80},
        {8'h04, 8'd13, 8'd0, 8'd8, 8'h00},
        {8'h04, 8'd1,  8'd1, 8'd0, 8'h00},
        {8'h07, 8'd5,  8'd0, 8'd1, 8'h08},
        {8'h07, 8'd6,  8'd0, 8'd2, 8'h08},
        {8'h07, 8'd12, 8'd0, 8'd2, 8'h02},
        {8'h07, 8'd15, 8'd0, 8'd8, 8'h04},
        {8'h07, 8'd4,  8'd1, 8'd0, 8'h00},
        {8'h08, 8'd7,  8'd0, 8'd0, 8'h20},
        {8'h08, 8'd10, 8'd0, 8'd1, 8'h80},
        {8'h08, 8'd14, 8'd0, 8'd1, 8'h08},
        {8'h08, 8'd16, 8'd0, 8'd3, 8'h10},
        {8'h08, 8'd6,  8'd1, 8'd0, 8'h00},
        {8'h05, 8'd10, 8'd1, 8'd0, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fixed_byte(input logic [7:0] t, input int i,
                                              input logic [7:0] b5, input logic [7:0] b31);
        logic d2;
        d2 = (t == 8'h08);
        case (i)
            0: return 8'd128;  1: return 8'd8;   2: return t;     3: return 8'd13;
            4: return 8'd10;   5: return b5;     6: return 8'd64; 8: return 8'd4;
            9: return 8'h25;   10: return 8'd1;  12: return 8'h82; 13: return 8'd8;
            15: return d2 ? 8'd0 : 8'd1;         16: return 8'd12; 17: return 8'd4;
            18: return 8'd12;  19: return d2 ? 8'd0 : 8'd1;        20: return 8'd2;
            21: return d2 ? 8'h00 : 8'h20;       23: return 8'h12; 27: return 8'd20;
            28: return 8'd15;  29: return 8'd20; 30: return 8'd45; 31: return b31;
            32: return 8'd20;  33: return 8'd8;  34: return 8'd20; 35: return 8'd8;
            default: return 8'h00;
        endcase
    endfunction

    task automatic run(input logic [7:0] t, input logic [4:0] e, input bit mid_start);
        int w;
        @(negedge clk);
        mem_type = t; size_log2 = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", busy, 1'b1);
        if (mid_start) begin
            repeat (20) @(negedge clk);
            mem_type = 8'h08; size_log2 = 5'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        check("R10", "done reached", done, 1'b1);
        check("R10", "busy low at done", busy, 1'b0);
        @(negedge clk);
        check("R10", "done one cycle", done, 1'b0);
    endtask

    task automatic check_image(input logic [7:0] t, input logic [7:0] b5, input logic [7:0] b31);
        logic [7:0] sum;
        logic [7:0] expv;
        sum = 8'h00;
        for (int i = 0; i < 256; i++) begin
            rd_addr = 8'(i);
            #1;
            if (i < 63) sum = sum + fixed_byte(t, i, b5, b31);
            expv = (i == 63) ? sum : fixed_byte(t, i, b5, b31);
            if (i == 5)       check("R6", "byte 5", rd_data, expv);
            else if (i == 31) check("R5", "byte 31", rd_data, expv);
            else if (i == 63) check("R9", "checksum byte 63", rd_data, expv);
            else if (i == 2 || i == 15 || i == 19 || i == 21)
                              check("R7", $sformatf("byte %0d", i), rd_data, expv);
            else              check("R8", $sformatf("byte %0d", i), rd_data, expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy at reset", busy, 1'b0);
        check("R1", "done at reset", done, 1'b0);
        check("R1", "error at reset", error, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] t, e, er, b5, b31;
            {t, e, er, b5, b31} = VEC[v];
            run(t, 5'(e), 1'b0);
            check("R2", $sformatf("error type 0x%0h exp %0d", t, e), error, er[0]);
            if (er == 8'd0) begin
                // table byte 5 / byte 31 encode the R3 halving and R4 split outcomes
                rd_addr = 8'd5;  #1;
                check("R3", $sformatf("bank byte type 0x%0h exp %0d", t, e), rd_data, b5);
                rd_addr = 8'd31; #1;
                check("R4", $sformatf("density type 0x%0h exp %0d", t, e), rd_data, b31);
                check_image(t, b5, b31);
            end
        end

        // start while busy is ignored: image must describe SDR, exponent 10
        run(8'h04, 5'd10, 1'b1);
        check("R10", "error after mid-run start", error, 1'b0);
        check_image(8'h04, 8'd2, 8'h80);

        // rejection followed by a good run clears error and rewrites all bytes
        run(8'h07, 5'd3, 1'b0);
        check("R2", "error on small DDR", error, 1'b1);
        run(8'h08, 5'd16, 1'b0);
        check("R2", "error cleared on good run", error, 1'b0);
        check_image(8'h08, 8'd3, 8'h10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule